// File: doc/BRIEF.md
# Pin Snapshot Edge Interrupt Emulator

This block produces per-pin edge interrupts for a switch-sensing peripheral that reports only the present level of its inputs and never records which input moved. Each time a new snapshot of the input word arrives, the block compares it with the previous one that it keeps cached. It then applies a software-programmed enable mask and, for each pin, a choice of rising and/or falling edges. Pins that qualify set sticky pending bits. A summary interrupt line stays high while any pending bit is set.

The transport that reads the peripheral also passes on two status flags that it finds in the replies: a fault flag and an interrupt flag. When either flag is seen, the block asks for a fresh snapshot. It keeps asking, one pass after another, for as long as new flags arrive during a pass. A fault flag sets a dedicated pending bit placed just above the pin bits. Requests to trigger on a level are refused with an error pulse.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset the pending vector is zero, `irq` and `snap_req` are low, and the enable mask and both edge selections read back as zero.
- R2: The first snapshot after reset only loads the cache and raises no pin pending bit, whatever the mask and selections are.
- R3: The changed pins are the snapshot XOR the cached word. The cache takes the new snapshot whenever any bit differs, including when every changed pin is masked.
- R4: Changed pins are ANDed with the enable mask. A write to address 0 loads mask bits SG_PINS-1:0 from `reg_wdata[SG_PINS-1:0]`. A write to address 1 loads mask bits N_PINS-1:SG_PINS from the low bits of `reg_wdata`. Each half reads back at its own address, right-aligned.
- R5: A pin sets its pending bit when it changed, is now 1, is enabled, and its rising selection is set.
- R6: A pin sets its pending bit when it changed, is now 0, is enabled, and its falling selection is set.
- R7: A write to address 2 sets the trigger type of one pin. `reg_wdata[7:0]` is the pin, bit 8 is rising, bit 9 is falling, bit 10 asks for level-high and bit 11 asks for level-low. If either level bit is set, or the pin index is above N_PINS, `reg_err` pulses in the cycle after the write and nothing changes. Pin index N_PINS (the fault source) is accepted and has no effect. Address 2 reads back the rising selections and address 4 reads back the falling selections.
- R8: A fault flag that is taken with a snapshot sets pending bit N_PINS. An interrupt flag on its own sets no pending bit.
- R9: A fault or interrupt flag seen outside a snapshot raises `snap_req` two cycles later. `snap_req` then stays high until a snapshot arrives. Flags that arrive after that snapshot start another request.
- R10: Pending bits stay set until a write to address 3 clears the bits that are 1 in `reg_wdata`. If a bit is set and cleared in the same cycle, the set wins. Address 3 reads back the pending vector, and `irq` is the OR of all pending bits.
- R11: A pin that leaves its level and returns to it between two snapshots raises no interrupt.
- R12: `evt_done` pulses one cycle after each snapshot. `evt_handled` is high with it when an enabled pin changed or a fault or interrupt flag was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snap_valid | input | 1 | Snapshot strobe |
| snap_state | input | 22 | Sampled input levels |
| hv_valid | input | 1 | Status flags present this cycle |
| hv_fault | input | 1 | Fault flag from the transport |
| hv_int | input | 1 | Interrupt flag from the transport |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| reg_err | output | 1 | Rejected trigger request, one-cycle pulse |
| snap_req | output | 1 | Request for a new snapshot |
| pending | output | 23 | Sticky pending bits, fault bit on top |
| irq | output | 1 | Summary interrupt |
| evt_done | output | 1 | One pass finished |
| evt_handled | output | 1 | That pass found something to handle |

## Verification
The bench builds the block with N_PINS=6 and SG_PINS=4. Both mask halves are then non-empty, and the fault bit sits at index 6. At this size, 32 passes are enough to give every pin each of the 32 combinations of previous level, new level, enable, rising select and falling select, and the expected pending word is computed bit by bit for every pass. The small width also lets the bench cover every rejected trigger case and the fault index, and drive the flag-driven request loop through repeated passes.

// File: rtl/pin_edge_irq_pkg.sv
// Shared register addresses, trigger field positions and sequencer types.
package pin_edge_irq_pkg;
    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 32;

    // Register addresses
    typedef enum logic [REG_ADDR_W-1:0] {
        A_EN_LO = 3'd0,
        A_EN_HI = 3'd1,
        A_TRIG  = 3'd2,
        A_PEND  = 3'd3,
        A_FALL  = 3'd4
    } reg_addr_e;

    // Trigger request field positions
    localparam int TRIG_PIN_W     = 8;
    localparam int TRIG_RISE_BIT  = 8;
    localparam int TRIG_FALL_BIT  = 9;
    localparam int TRIG_LVLH_BIT  = 10;
    localparam int TRIG_LVLL_BIT  = 11;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic fault;
        logic intr;
    } hv_flags_t;
endpackage

// File: rtl/pin_edge_cfg.sv
// Configuration registers: split enable mask and per-pin edge selections.
// Assumes SG_PINS < N_PINS. Level trigger requests and out-of-range pins
// are refused with a one-cycle error pulse; the fault index is accepted
// and ignored.
module pin_edge_cfg
    import pin_edge_irq_pkg::*;
#(
    parameter int N_PINS  = 22,
    parameter int SG_PINS = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [N_PINS-1:0]     en_mask,
    output logic [N_PINS-1:0]     rise_sel,
    output logic [N_PINS-1:0]     fall_sel,
    output logic                  reg_err
);
    localparam int SP_PINS = N_PINS - SG_PINS;

    logic [TRIG_PIN_W-1:0] pin_idx;
    logic                  trig_wr;
    logic                  trig_bad;
    logic                  trig_ok;

    // Decode a trigger-type request and decide whether it is legal
    always_comb begin
        pin_idx  = reg_wdata[TRIG_PIN_W-1:0];
        trig_wr  = reg_we && (reg_addr == A_TRIG);
        trig_bad = reg_wdata[TRIG_LVLH_BIT] || reg_wdata[TRIG_LVLL_BIT]
                   || (pin_idx > TRIG_PIN_W'(N_PINS));
        trig_ok  = trig_wr && !trig_bad;
    end

    // Error pulse for refused requests
    always_ff @(posedge clk) begin
        if (!rst_n) reg_err <= 1'b0;
        else        reg_err <= trig_wr && trig_bad;
    end

    // Switch-to-ground half of the mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_mask[SG_PINS-1:0] <= '0;
        else if (reg_we && reg_addr == A_EN_LO)
            en_mask[SG_PINS-1:0] <= reg_wdata[SG_PINS-1:0];
    end

    // Programmable half of the mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_mask[N_PINS-1:SG_PINS] <= '0;
        else if (reg_we && reg_addr == A_EN_HI)
            en_mask[N_PINS-1:SG_PINS] <= reg_wdata[SP_PINS-1:0];
    end

    // Per-pin edge selection registers
    for (genvar g = 0; g < N_PINS; g++) begin : g_sel
        logic hit;
        assign hit = trig_ok && (pin_idx == TRIG_PIN_W'(g));

        // Load this pin's rise/fall choice on a legal request
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_sel[g] <= 1'b0;
                fall_sel[g] <= 1'b0;
            end else if (hit) begin
                rise_sel[g] <= reg_wdata[TRIG_RISE_BIT];
                fall_sel[g] <= reg_wdata[TRIG_FALL_BIT];
            end
        end
    end
endmodule

// File: rtl/pin_edge_detect.sv
// Snapshot comparator: keeps the previous input word and qualifies the
// differences into per-pin edge fires. Assumes snapshots are single-cycle
// strobes. The first snapshot after reset primes the cache silently.
module pin_edge_detect #(
    parameter int N_PINS = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_valid,
    input  logic [N_PINS-1:0] snap_state,
    input  logic [N_PINS-1:0] en_mask,
    input  logic [N_PINS-1:0] rise_sel,
    input  logic [N_PINS-1:0] fall_sel,
    output logic [N_PINS-1:0] fire,
    output logic              live_any,
    output logic              primed
);
    logic [N_PINS-1:0] cache_q;
    logic [N_PINS-1:0] changed;
    logic [N_PINS-1:0] live;

    // Differences, masking and edge qualification for this snapshot
    always_comb begin
        changed  = snap_state ^ cache_q;
        live     = (snap_valid && primed) ? (changed & en_mask) : '0;
        fire     = (live & snap_state & rise_sel) | (live & ~snap_state & fall_sel);
        live_any = |live;
    end

    // Cache update: replaced on any difference, masked pins included
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_q <= '0;
            primed  <= 1'b0;
        end else if (snap_valid) begin
            primed <= 1'b1;
            if (!primed || (changed != '0))
                cache_q <= snap_state;
        end
    end
endmodule

// File: rtl/pin_edge_seq.sv
// Flag accumulator and snapshot request sequencer. Flags seen with a
// snapshot belong to that pass; flags seen later are held and cause a
// fresh request, so passes repeat while flags keep arriving.
module pin_edge_seq
    import pin_edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hv_valid,
    input  logic hv_fault,
    input  logic hv_int,
    input  logic snap_valid,
    output logic snap_req,
    output logic take_fault,
    output logic take_int
);
    hv_flags_t  acc_q, acc_d, arrive;
    seq_state_e st_q, st_d;

    // Flags arriving now and the flags consumed by a snapshot
    always_comb begin
        arrive.fault = hv_valid && hv_fault;
        arrive.intr  = hv_valid && hv_int;
        take_fault   = snap_valid && (acc_q.fault || arrive.fault);
        take_int     = snap_valid && (acc_q.intr  || arrive.intr);
        acc_d        = snap_valid ? hv_flags_t'('0) : hv_flags_t'(acc_q | arrive);
    end

    // Next request state
    always_comb begin
        st_d = st_q;
        case (st_q)
            SEQ_IDLE: if ((acc_q != '0) && !snap_valid) st_d = SEQ_WAIT;
            SEQ_WAIT: if (snap_valid) st_d = SEQ_IDLE;
            default:  st_d = SEQ_IDLE;
        endcase
    end

    // State and accumulator registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            st_q  <= SEQ_IDLE;
        end else begin
            acc_q <= acc_d;
            st_q  <= st_d;
        end
    end

    assign snap_req = (st_q == SEQ_WAIT);
endmodule

// File: rtl/pin_edge_pending.sv
// Sticky pending bits with write-one-to-clear; a set wins over a clear
// in the same cycle. The summary line is the OR of all bits.
module pin_edge_pending #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] pend,
    output logic         irq
);
    logic [W-1:0] clr_eff;

    // Clear bits only on a clear write
    always_comb clr_eff = clr_we ? clr_vec : '0;

    // Sticky update
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_eff) | set_vec;
    end

    assign irq = |pend;
endmodule

// File: rtl/pin_edge_irq.sv
// Top: edge interrupts emulated from pin snapshots. Connects configuration,
// snapshot comparison, flag sequencing and pending state, and provides the
// register read mux and the per-pass completion report. Assumes
// N_PINS + 1 <= 32 so every readable word fits the data bus.
module pin_edge_irq
    import pin_edge_irq_pkg::*;
#(
    parameter int N_PINS  = 22,
    parameter int SG_PINS = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snap_valid,
    input  logic [N_PINS-1:0]     snap_state,
    input  logic                  hv_valid,
    input  logic                  hv_fault,
    input  logic                  hv_int,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic                  reg_err,
    output logic                  snap_req,
    output logic [N_PINS:0]       pending,
    output logic                  irq,
    output logic                  evt_done,
    output logic                  evt_handled
);
    localparam int SP_PINS = N_PINS - SG_PINS;
    localparam int PEND_W  = N_PINS + 1;

    logic [N_PINS-1:0] en_mask, rise_sel, fall_sel, fire;
    logic              live_any, cache_primed;
    logic              take_fault, take_int;
    logic              clr_wr;
    logic              unused_wdata;

    pin_edge_cfg #(.N_PINS(N_PINS), .SG_PINS(SG_PINS)) cfg_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .en_mask(en_mask), .rise_sel(rise_sel),
        .fall_sel(fall_sel), .reg_err(reg_err)
    );

    pin_edge_detect #(.N_PINS(N_PINS)) det_i (
        .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_state(snap_state),
        .en_mask(en_mask), .rise_sel(rise_sel), .fall_sel(fall_sel),
        .fire(fire), .live_any(live_any), .primed(cache_primed)
    );

    pin_edge_seq seq_i (
        .clk(clk), .rst_n(rst_n), .hv_valid(hv_valid), .hv_fault(hv_fault),
        .hv_int(hv_int), .snap_valid(snap_valid), .snap_req(snap_req),
        .take_fault(take_fault), .take_int(take_int)
    );

    assign clr_wr       = reg_we && (reg_addr == A_PEND);
    assign unused_wdata = ^reg_wdata;

    pin_edge_pending #(.W(PEND_W)) pend_i (
        .clk(clk), .rst_n(rst_n), .set_vec({take_fault, fire}),
        .clr_we(clr_wr), .clr_vec(reg_wdata[PEND_W-1:0]),
        .pend(pending), .irq(irq)
    );

    // Per-pass completion report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_done    <= 1'b0;
            evt_handled <= 1'b0;
        end else begin
            evt_done    <= snap_valid;
            evt_handled <= snap_valid && (live_any || take_fault || take_int);
        end
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_EN_LO: reg_rdata[SG_PINS-1:0] = en_mask[SG_PINS-1:0];
            A_EN_HI: reg_rdata[SP_PINS-1:0] = en_mask[N_PINS-1:SG_PINS];
            A_TRIG:  reg_rdata[N_PINS-1:0]  = rise_sel;
            A_PEND:  reg_rdata[PEND_W-1:0]  = pending;
            A_FALL:  reg_rdata[N_PINS-1:0]  = fall_sel;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_edge_irq_chk.sv
// Checker for pin_edge_irq: request holding, refused-request stability,
// silent priming, masking, stickiness and fault raising.
module pin_edge_irq_chk #(
    parameter int N_PINS = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snap_valid,
    input logic              snap_req,
    input logic              hv_valid,
    input logic              hv_fault,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic              reg_err,
    input logic [N_PINS-1:0] rise_sel,
    input logic [N_PINS-1:0] fall_sel,
    input logic [N_PINS-1:0] en_mask,
    input logic              cache_primed,
    input logic [N_PINS:0]   pending
);
    logic clr_wr;
    assign clr_wr = reg_we && (reg_addr == 3'd3);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req && !snap_valid |=> snap_req);

    p_reject_keeps_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> ($stable(rise_sel) && $stable(fall_sel)));

    p_first_snap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid && !cache_primed && !clr_wr
        |=> pending[N_PINS-1:0] == $past(pending[N_PINS-1:0]));

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid && (en_mask == '0) && !clr_wr
        |=> pending[N_PINS-1:0] == $past(pending[N_PINS-1:0]));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((pending & $past(pending)) == $past(pending)));

    p_fault_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid && hv_valid && hv_fault |=> pending[N_PINS]);
endmodule

bind pin_edge_irq pin_edge_irq_chk #(.N_PINS(N_PINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_req(snap_req),
    .hv_valid(hv_valid), .hv_fault(hv_fault), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_err(reg_err), .rise_sel(rise_sel),
    .fall_sel(fall_sel), .en_mask(en_mask), .cache_primed(cache_primed),
    .pending(pending)
);

// File: tb/pin_edge_irq_tb_top.sv
`timescale 1ns/1ps
module pin_edge_irq_tb_top;
    localparam int N  = 6;
    localparam int SG = 4;
    localparam logic [31:0] ALL_P = 32'h7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snap_valid = 1'b0;
    logic [N-1:0] snap_state = '0;
    logic        hv_valid = 1'b0, hv_fault = 1'b0, hv_int = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err, snap_req, irq, evt_done, evt_handled;
    logic [N:0]  pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pin_edge_irq #(.N_PINS(N), .SG_PINS(SG)) dut_i (
        .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_state(snap_state),
        .hv_valid(hv_valid), .hv_fault(hv_fault), .hv_int(hv_int),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .snap_req(snap_req),
        .pending(pending), .irq(irq), .evt_done(evt_done), .evt_handled(evt_handled)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic snap(input logic [N-1:0] s, input logic f, input logic i);
        snap_valid = 1'b1; snap_state = s;
        hv_valid = f | i; hv_fault = f; hv_int = i;
        @(negedge clk);
        snap_valid = 1'b0; hv_valid = 1'b0; hv_fault = 1'b0; hv_int = 1'b0;
    endtask

    task automatic trig(input int pin, input logic r, input logic f);
        wr(3'd2, 32'(pin) | (32'(r) << 8) | (32'(f) << 9));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pending", 32'(pending), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 snap_req", 32'(snap_req), 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 readback", d, 0);
        end

        // R4 mask halves
        wr(3'd0, 32'h5); wr(3'd1, 32'h2);
        rd(3'd0, d); check("R4 low half", d, 32'h5);
        rd(3'd1, d); check("R4 high half", d, 32'h2);
        wr(3'd0, 32'hF); wr(3'd1, 32'h3);

        for (int p = 0; p < N; p++) trig(p, 1'b1, 1'b1);
        rd(3'd2, d); check("R7 rise readback", d, 32'h3F);
        rd(3'd4, d); check("R7 fall readback", d, 32'h3F);

        // R7 refused requests
        wr(3'd2, 32'h401); check("R7 level-high err", 32'(reg_err), 1);
        wr(3'd2, 32'h802); check("R7 level-low err", 32'(reg_err), 1);
        wr(3'd2, 32'h007); check("R7 range err", 32'(reg_err), 1);
        wr(3'd2, 32'h106); check("R7 fault index ok", 32'(reg_err), 0);
        rd(3'd2, d); check("R7 rise unchanged", d, 32'h3F);
        rd(3'd4, d); check("R7 fall unchanged", d, 32'h3F);
        trig(2, 1'b0, 1'b1); check("R7 legal no err", 32'(reg_err), 0);
        rd(3'd2, d); check("R7 rise pin2", d, 32'h3B);
        trig(2, 1'b1, 1'b1);

        // R2 first snapshot is silent
        snap(6'h2D, 1'b0, 1'b0);
        check("R2 prime", 32'(pending), 0);
        check("R12 done", 32'(evt_done), 1);
        check("R12 prime not handled", 32'(evt_handled), 0);

        // R11 pulse between snapshots
        snap_state = 6'h12; @(negedge clk); snap_state = 6'h2D;
        snap(6'h2D, 1'b0, 1'b0);
        check("R11 glitch", 32'(pending), 0);

        // R6 falling, R5 rising, R10 sticky
        snap(6'h2C, 1'b0, 1'b0);
        check("R6 fall", 32'(pending), 32'h01);
        snap(6'h2E, 1'b0, 1'b0);
        check("R5 rise sticky R10", 32'(pending), 32'h03);
        check("R10 irq", 32'(irq), 1);
        wr(3'd3, 32'h01); check("R10 partial clear", 32'(pending), 32'h02);
        rd(3'd3, d); check("R10 readback", d, 32'h02);
        wr(3'd3, 32'h02); check("R10 cleared", 32'(pending), 0);
        check("R10 irq low", 32'(irq), 0);

        // R10 set wins over clear
        snap_valid = 1'b1; snap_state = 6'h2F;
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = ALL_P;
        @(negedge clk);
        snap_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        check("R10 set wins", 32'(pending), 32'h01);
        wr(3'd3, ALL_P);

        // R8 flags
        snap(6'h2F, 1'b1, 1'b0);
        check("R8 fault", 32'(pending), 32'h40);
        check("R12 fault handled", 32'(evt_handled), 1);
        wr(3'd3, ALL_P);
        snap(6'h2F, 1'b0, 1'b1);
        check("R8 int only", 32'(pending), 0);
        check("R12 int handled", 32'(evt_handled), 1);
        snap(6'h2F, 1'b0, 1'b0);
        check("R12 nothing", 32'(evt_handled), 0);

        // R9 request and repeat
        hv_valid = 1'b1; hv_int = 1'b1;
        @(negedge clk);
        hv_valid = 1'b0; hv_int = 1'b0;
        check("R9 not yet", 32'(snap_req), 0);
        @(negedge clk); check("R9 req", 32'(snap_req), 1);
        @(negedge clk); @(negedge clk); check("R9 hold", 32'(snap_req), 1);
        snap(6'h2F, 1'b0, 1'b0);
        check("R9 drop", 32'(snap_req), 0);
        hv_valid = 1'b1; hv_fault = 1'b1;
        @(negedge clk);
        hv_valid = 1'b0; hv_fault = 1'b0;
        @(negedge clk); check("R9 repeat", 32'(snap_req), 1);
        snap(6'h2F, 1'b0, 1'b0);
        check("R8 deferred fault", 32'(pending), 32'h40);
        @(negedge clk); check("R9 idle", 32'(snap_req), 0);
        wr(3'd3, ALL_P);

        // R3 R4 R5 R6 sweep: every pin sees all 32 combinations
        for (int c = 0; c < 32; c++) begin
            logic [N-1:0] pv, nv, en, rs, fs, exp;
            for (int p = 0; p < N; p++) begin
                int k;
                k = (c + p * 5) % 32;
                pv[p] = k[0]; nv[p] = k[1]; en[p] = k[2]; rs[p] = k[3]; fs[p] = k[4];
            end
            wr(3'd0, 0); wr(3'd1, 0);
            snap(pv, 1'b0, 1'b0);
            check("R4 masked", 32'(pending), 0);
            wr(3'd0, 32'(en[SG-1:0])); wr(3'd1, 32'(en[N-1:SG]));
            for (int p = 0; p < N; p++) trig(p, rs[p], fs[p]);
            snap(nv, 1'b0, 1'b0);
            exp = ((pv ^ nv) & en & nv & rs) | ((pv ^ nv) & en & ~nv & fs);
            check("R3 R5 R6 sweep", 32'(pending), 32'(exp));
            check("R10 sweep irq", 32'(irq), 32'(exp != 0));
            check("R12 sweep handled", 32'(evt_handled), 32'(((pv ^ nv) & en) != 0));
            wr(3'd3, ALL_P);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule